// File: doc/BRIEF.md
# Eight-bit ALU with registered status flags

This block is the arithmetic and logic stage of a small 8-bit accumulator-style processor core. Each cycle it takes a working-register value and a file-register value, together with a 4-bit operation code and a destination bit. It produces an 8-bit result, a skip request, and the next values of the carry (C), digit-carry (DC) and zero (Z) flags, each with its own write enable. The datapath is purely combinational. The three flags live in a small status register inside the block, and that register also feeds the current flags back into the datapath.

Each operation touches only its own set of flags. Addition and subtraction write all three flags. The bitwise operations write only Z. The rotates pass their bits through C. The skip variants of increment and decrement raise a skip request and leave every flag alone. Separate set and clear commands for each flag let the core write individual status bits, and these commands override the ALU in the same cycle. The status register loads only when the instruction-valid strobe is high.

Top module: `alu8_flag_core`

## Requirements
- R1: While reset is low, and on the first cycle after it, the flags (bit 0 = C, bit 1 = DC, bit 2 = Z) are all zero.
- R2: Opcode 0 adds W to F. C is the carry out of bit 7, DC is the carry out of bit 3, Z is set when the 8-bit sum is zero, and all three write enables are high.
- R3: Opcode 1 computes F minus W. C=1 means no borrow and DC=1 means no borrow out of the low nibble; Z follows the result and all three flags are written.
- R4: Opcodes 2 (AND), 3 (OR) and 4 (XOR) write only Z; C and DC keep their prior values.
- R5: Opcode 9 rotates F left and opcode 10 rotates it right, both through C. The bit shifted out becomes the new C and the old C fills the vacated bit; only C is written.
- R6: Opcode 5 computes F+1 and opcode 7 computes F-1, both wrapping. Each writes only Z, which is set when the result is zero.
- R7: Opcodes 6 (increment) and 8 (decrement) produce F+1 and F-1, raise skip when the result is zero, and write no flag. No other opcode raises skip.
- R8: Opcode 11 swaps the two nibbles of F and writes no flag.
- R9: Opcode 12 passes F through and sets Z according to whether it is zero. Opcode 13 yields 0 and sets Z. Opcodes 14 and 15 pass F through and write no flag.
- R10: The destination output equals the destination-select input for every opcode.
- R11: The per-flag set and clear commands (same bit order as R1) override the ALU update in the same cycle. Set wins over clear.
- R12: When the instruction-valid strobe is low, the flags do not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction valid; enables the status update |
| op_code | input | 4 | Operation select |
| dest_sel | input | 1 | Destination select: 1 = file register, 0 = W |
| w_in | input | 8 | Working-register operand |
| f_in | input | 8 | File-register operand |
| flag_set | input | 3 | Per-flag set command |
| flag_clr | input | 3 | Per-flag clear command |
| result | output | 8 | ALU result |
| dest_file | output | 1 | Destination select passed through |
| skip | output | 1 | Skip request from the skip-if-zero forms |
| flag_next | output | 3 | Flag values proposed by the ALU |
| flag_we | output | 3 | Per-flag write enables from the ALU |
| flags_q | output | 3 | Current registered flags |

## Verification
The assertions assume that the opcode, operands and commands are stable across each rising edge, and that reset is released away from a clock edge. The flag-retention properties only apply in cycles where no set or clear command is active, because a command may legally change any flag. The bench changes every input at the falling edge and releases reset there. It drives the named corner values with no commands active and, separately, a random mix of commands, opcodes and valid strobes, so both the guarded and unguarded conditions occur.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int NW    = DW / 2;
  localparam int NFLAG = 3;
  localparam int FC    = 0;
  localparam int FDC   = 1;
  localparam int FZ    = 2;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_INC   = 4'd5,
    OP_INCSZ = 4'd6,
    OP_DEC   = 4'd7,
    OP_DECSZ = 4'd8,
    OP_RL    = 4'd9,
    OP_RR    = 4'd10,
    OP_SWAP  = 4'd11,
    OP_MOV   = 4'd12,
    OP_CLR   = 4'd13,
    OP_PASSA = 4'd14,
    OP_PASSB = 4'd15
  } alu_op_e;

  // {carry, digit carry, result}
  function automatic logic [DW+1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] full;
    logic [NW:0] low;
    full = {1'b0, a} + {1'b0, b};
    low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]};
    return {full[DW], low[NW], full[DW-1:0]};
  endfunction

  // minuend - subtrahend, carries reported as inverted borrows
  function automatic logic [DW+1:0] f_sub(input logic [DW-1:0] m, input logic [DW-1:0] s);
    logic [DW:0] full;
    logic [NW:0] low;
    full = {1'b0, m} - {1'b0, s};
    low  = {1'b0, m[NW-1:0]} - {1'b0, s[NW-1:0]};
    return {~full[DW], ~low[NW], full[DW-1:0]};
  endfunction

  // {carry out, result}
  function automatic logic [DW:0] f_rotl(input logic [DW-1:0] v, input logic cin);
    return {v, cin};
  endfunction

  function automatic logic [DW:0] f_rotr(input logic [DW-1:0] v, input logic cin);
    return {v[0], cin, v[DW-1:1]};
  endfunction

  function automatic logic [DW-1:0] f_swap(input logic [DW-1:0] v);
    return {v[NW-1:0], v[DW-1:NW]};
  endfunction
endpackage

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  alu_op_e              op,
  input  logic [DW-1:0]        w_val,
  input  logic [DW-1:0]        f_val,
  input  logic [NFLAG-1:0]     cur_flags,
  output logic [DW-1:0]        res,
  output logic [NFLAG-1:0]     nxt_flags,
  output logic [NFLAG-1:0]     upd_en,
  output logic                 skip_req
);
  logic [DW+1:0] arith;
  logic [DW:0]   rot;
  logic          c_new;
  logic          dc_new;
  logic          res_zero;

  always_comb begin
    arith    = '0;
    rot      = '0;
    res      = f_val;
    c_new    = cur_flags[FC];
    dc_new   = cur_flags[FDC];
    upd_en   = '0;
    skip_req = 1'b0;
    unique case (op)
      OP_ADD: begin
        arith  = f_add(w_val, f_val);
        res    = arith[DW-1:0];
        c_new  = arith[DW+1];
        dc_new = arith[DW];
        upd_en = 3'b111;
      end
      OP_SUB: begin
        arith  = f_sub(f_val, w_val);
        res    = arith[DW-1:0];
        c_new  = arith[DW+1];
        dc_new = arith[DW];
        upd_en = 3'b111;
      end
      OP_AND: begin res = w_val & f_val; upd_en[FZ] = 1'b1; end
      OP_OR:  begin res = w_val | f_val; upd_en[FZ] = 1'b1; end
      OP_XOR: begin res = w_val ^ f_val; upd_en[FZ] = 1'b1; end
      OP_INC: begin res = f_val + 1'b1; upd_en[FZ] = 1'b1; end
      OP_DEC: begin res = f_val - 1'b1; upd_en[FZ] = 1'b1; end
      OP_INCSZ: begin
        res      = f_val + 1'b1;
        skip_req = (res == '0);
      end
      OP_DECSZ: begin
        res      = f_val - 1'b1;
        skip_req = (res == '0);
      end
      OP_RL: begin
        rot        = f_rotl(f_val, cur_flags[FC]);
        res        = rot[DW-1:0];
        c_new      = rot[DW];
        upd_en[FC] = 1'b1;
      end
      OP_RR: begin
        rot        = f_rotr(f_val, cur_flags[FC]);
        res        = rot[DW-1:0];
        c_new      = rot[DW];
        upd_en[FC] = 1'b1;
      end
      OP_SWAP: res = f_swap(f_val);
      OP_MOV:  begin res = f_val; upd_en[FZ] = 1'b1; end
      OP_CLR:  begin res = '0;    upd_en[FZ] = 1'b1; end
      default: res = f_val;
    endcase
  end

  assign res_zero  = (res == '0);
  assign nxt_flags = {res_zero, dc_new, c_new};
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NFLAG-1:0] alu_val,
  input  logic [NFLAG-1:0] alu_en,
  input  logic [NFLAG-1:0] cmd_set,
  input  logic [NFLAG-1:0] cmd_clr,
  output logic [NFLAG-1:0] q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    logic d;
    always_comb begin
      if (cmd_set[i])      d = 1'b1;
      else if (cmd_clr[i]) d = 1'b0;
      else if (alu_en[i])  d = alu_val[i];
      else                 d = q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= 1'b0;
      else if (load) q[i] <= d;
    end
  end
endmodule

// File: rtl/alu8_flag_core.sv
module alu8_flag_core
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_vld,
  input  logic [3:0]       op_code,
  input  logic             dest_sel,
  input  logic [DW-1:0]    w_in,
  input  logic [DW-1:0]    f_in,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [DW-1:0]    result,
  output logic             dest_file,
  output logic             skip,
  output logic [NFLAG-1:0] flag_next,
  output logic [NFLAG-1:0] flag_we,
  output logic [NFLAG-1:0] flags_q
);
  alu_op_e op_e;
  assign op_e      = alu_op_e'(op_code);
  assign dest_file = dest_sel;

  alu8_datapath i_dp (
    .op        (op_e),
    .w_val     (w_in),
    .f_val     (f_in),
    .cur_flags (flags_q),
    .res       (result),
    .nxt_flags (flag_next),
    .upd_en    (flag_we),
    .skip_req  (skip)
  );

  alu8_flag_reg i_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (instr_vld),
    .alu_val (flag_next),
    .alu_en  (flag_we),
    .cmd_set (flag_set),
    .cmd_clr (flag_clr),
    .q       (flags_q)
  );
endmodule

// File: rtl/alu8_flag_core_chk.sv
module alu8_flag_core_chk
  import alu8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             instr_vld,
  input logic [3:0]       op_code,
  input logic [DW-1:0]    f_in,
  input logic [DW-1:0]    result,
  input logic             skip,
  input logic [NFLAG-1:0] flag_set,
  input logic [NFLAG-1:0] flag_clr,
  input logic [NFLAG-1:0] flags_q
);
  logic no_cmd;
  assign no_cmd = (flag_set == '0) && (flag_clr == '0);

  // R1
  rst_flags_chk: assert property (@(posedge clk) !rst_n |=> flags_q == '0);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld |=> $stable(flags_q));

  // R8
  swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld && op_code == OP_SWAP && no_cmd |=> $stable(flags_q));

  // R4
  logic_cdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld && no_cmd && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)
    |=> flags_q[FDC:FC] == $past(flags_q[FDC:FC]));

  // R7
  skip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> ((op_code == OP_INCSZ || op_code == OP_DECSZ) && result == '0));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld && flag_set != '0 |=> (flags_q & $past(flag_set)) == $past(flag_set));

  // R5
  rotl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld && op_code == OP_RL && no_cmd |=> flags_q[FC] == $past(f_in[DW-1]));
endmodule

bind alu8_flag_core alu8_flag_core_chk i_chk (.*);

// File: tb/test_alu8_flag_core.sv
module test_alu8_flag_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_vld = 1'b0;
  logic [3:0] op_code = '0;
  logic       dest_sel = 1'b0;
  logic [7:0] w_in = '0, f_in = '0;
  logic [2:0] flag_set = '0, flag_clr = '0;
  logic [7:0] result;
  logic       dest_file, skip;
  logic [2:0] flag_next, flag_we, flags_q;

  always #4 clk = ~clk;

  alu8_flag_core i_alu8_flag_core (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [2:0] mfl = '0;   // bench model of flags: bit0 C, bit1 DC, bit2 Z

  typedef struct {
    logic [7:0] res; logic skp; logic dst;
    logic [2:0] we; logic [2:0] nxt; logic [2:0] after; string tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
                       input logic d, input logic v, input logic [2:0] s, input logic [2:0] c,
                       input string tag);
    exp_t e;
    int r; bit cc, dd, sk; logic [2:0] en;
    cc = mfl[0]; dd = mfl[1]; sk = 0; en = 3'b000; r = f;
    case (op)
      0: begin r = (w + f) % 256; cc = (int'(w) + int'(f)) > 255;
               dd = (int'(w % 16) + int'(f % 16)) > 15; en = 3'b111; end
      1: begin r = (256 + f - w) % 256; cc = f >= w; dd = (f % 16) >= (w % 16); en = 3'b111; end
      2: begin r = w & f; en = 3'b100; end
      3: begin r = w | f; en = 3'b100; end
      4: begin r = w ^ f; en = 3'b100; end
      5: begin r = (f + 1) % 256; en = 3'b100; end
      7: begin r = (f + 255) % 256; en = 3'b100; end
      6: begin r = (f + 1) % 256; sk = (r == 0); end
      8: begin r = (f + 255) % 256; sk = (r == 0); end
      9: begin r = ((f * 2) % 256) + mfl[0]; cc = f[7]; en = 3'b001; end
      10: begin r = (f / 2) + (mfl[0] ? 128 : 0); cc = f[0]; en = 3'b001; end
      11: begin r = ((f % 16) * 16) + (f / 16); end
      12: begin r = f; en = 3'b100; end
      13: begin r = 0; en = 3'b100; end
      default: r = f;
    endcase
    e.res = r[7:0]; e.skp = sk; e.dst = d; e.we = en;
    e.nxt = {r == 0, dd, cc};
    e.after = mfl;
    if (v)
      for (int i = 0; i < 3; i++)
        e.after[i] = s[i] ? 1'b1 : c[i] ? 1'b0 : en[i] ? e.nxt[i] : mfl[i];
    mfl = e.after;
    e.tag = tag;
    @(negedge clk);
    op_code = op; w_in = w; f_in = f; dest_sel = d; instr_vld = v;
    flag_set = s; flag_clr = c;
    sb.push_back(e);
  endtask

  // monitor: combinational outputs just before the edge, flags just after it
  initial forever begin
    exp_t e;
    @(negedge clk);
    #3;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(result == e.res, {e.tag, " result"}, result, e.res);
      chk(skip == e.skp, {e.tag, " skip"}, {7'b0, skip}, {7'b0, e.skp});
      chk(dest_file == e.dst, "R10 dest", {7'b0, dest_file}, {7'b0, e.dst});
      chk(flag_we == e.we, {e.tag, " we"}, {5'b0, flag_we}, {5'b0, e.we});
      chk((flag_next & e.we) == (e.nxt & e.we), {e.tag, " next"},
          {5'b0, flag_next & e.we}, {5'b0, e.nxt & e.we});
      @(posedge clk);
      #1;
      chk(flags_q == e.after, {e.tag, " flags"}, {5'b0, flags_q}, {5'b0, e.after});
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flags_q == 3'b000, "R1 in reset", {5'b0, flags_q}, 8'h00);
    rst_n = 1'b1;
    #1 chk(flags_q == 3'b000, "R1 after reset", {5'b0, flags_q}, 8'h00);
    // R2 addition
    do_op(0, 8'h00, 8'h00, 0, 1, 0, 0, "R2 0+0");
    do_op(0, 8'h88, 8'h88, 1, 1, 0, 0, "R2 88+88");
    do_op(0, 8'h80, 8'h80, 0, 1, 0, 0, "R2 80+80");
    do_op(0, 8'hFF, 8'h01, 1, 1, 0, 0, "R2 01+FF");
    do_op(0, 8'h08, 8'h08, 0, 1, 0, 0, "R2 08+08");
    // R3 subtraction F-W
    do_op(1, 8'h00, 8'h00, 0, 1, 0, 0, "R3 0-0");
    do_op(1, 8'h01, 8'h00, 0, 1, 0, 0, "R3 0-1");
    do_op(1, 8'h80, 8'h00, 1, 1, 0, 0, "R3 0-80");
    do_op(1, 8'h01, 8'h80, 0, 1, 0, 0, "R3 80-1");
    do_op(1, 8'h88, 8'h88, 0, 1, 0, 0, "R3 88-88");
    // R4 logic ops keep C/DC (set them first)
    do_op(14, 8'h00, 8'h00, 0, 1, 3'b011, 0, "R11 set C DC");
    do_op(2, 8'h01, 8'h00, 0, 1, 0, 0, "R4 and zero");
    do_op(3, 8'h01, 8'h00, 0, 1, 0, 0, "R4 or");
    do_op(4, 8'hFF, 8'hFF, 1, 1, 0, 0, "R4 xor");
    do_op(14, 8'h00, 8'h00, 0, 1, 0, 3'b011, "R11 clr C DC");
    do_op(2, 8'hF0, 8'h3C, 0, 1, 0, 0, "R4 and clear cdc");
    // R5 rotates
    do_op(9, 8'h00, 8'h80, 0, 1, 0, 0, "R5 rl out");
    do_op(9, 8'h00, 8'h01, 0, 1, 0, 0, "R5 rl in");
    do_op(10, 8'h00, 8'h01, 1, 1, 0, 0, "R5 rr out");
    do_op(10, 8'h00, 8'h00, 1, 1, 0, 0, "R5 rr in");
    // R6 inc/dec
    do_op(5, 8'h00, 8'hFF, 0, 1, 0, 0, "R6 inc wrap");
    do_op(5, 8'h00, 8'h41, 0, 1, 0, 0, "R6 inc");
    do_op(7, 8'h00, 8'h01, 0, 1, 0, 0, "R6 dec zero");
    do_op(7, 8'h00, 8'h00, 0, 1, 0, 0, "R6 dec wrap");
    // R7 skip forms leave flags
    do_op(14, 8'h00, 8'h00, 0, 1, 0, 3'b100, "R11 clr Z");
    do_op(6, 8'h00, 8'hFF, 0, 1, 0, 0, "R7 incsz zero");
    do_op(6, 8'h00, 8'h10, 0, 1, 0, 0, "R7 incsz nz");
    do_op(8, 8'h00, 8'h01, 1, 1, 0, 0, "R7 decsz zero");
    do_op(8, 8'h00, 8'h00, 1, 1, 0, 0, "R7 decsz nz");
    // R8 swap
    do_op(11, 8'h00, 8'h0F, 1, 1, 0, 0, "R8 swap");
    do_op(11, 8'h00, 8'hA5, 0, 1, 0, 0, "R8 swap2");
    // R9 move, clear, pass
    do_op(12, 8'h00, 8'h00, 0, 1, 0, 0, "R9 mov zero");
    do_op(12, 8'h00, 8'h05, 1, 1, 0, 0, "R9 mov nz");
    do_op(13, 8'h00, 8'h77, 1, 1, 0, 0, "R9 clr");
    do_op(15, 8'h00, 8'h00, 0, 1, 0, 0, "R9 pass");
    // R11 priority over ALU, set over clear
    do_op(0, 8'h80, 8'h80, 0, 1, 3'b000, 3'b101, "R11 clr over add");
    do_op(0, 8'h00, 8'h01, 0, 1, 3'b111, 3'b111, "R11 set over clr");
    // R12 no update when invalid
    do_op(13, 8'h00, 8'h00, 0, 0, 0, 0, "R12 idle clr");
    do_op(1, 8'h01, 8'h00, 0, 0, 3'b000, 3'b111, "R12 idle cmd");
    // mixed random traffic
    for (int k = 0; k < 300; k++)
      do_op(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 4 == 0) ? 3'($urandom) : 3'b0,
            ($urandom % 4 == 0) ? 3'($urandom) : 3'b0, "R2 R5 R11 R12 mix");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule